// File: doc/BRIEF.md
# Interlaced Active-Video Region Generator

This block tracks where a sample lies inside an interlaced television frame. Every time the pixel-advance strobe is high on a clock edge, a pixel counter steps along the line. At the end of a line the line counter moves on, and at the end of the frame the line counter returns to line one. From these two positions the block works out a horizontal window, a vertical window and a field flag. The AND of the two windows is registered as one ACTIVE flag, and an output formatter uses that flag to keep only the visible part of the picture.

A two-bit standard select picks one of four timings: 525-line or 625-line frames, each with rectangular (601) or square-pixel sampling. The per-line pixel totals and active widths are parameters. Their defaults are the broadcast values. The horizontal window sits just before a parameterised front porch at the end of each line. Sync detection and waveform generation are left to other blocks.

Top module: `vidRegionGen`

## Requirements
- R1: While `rst` is high on a clock edge, the outputs become pixel count 0, line count 1, field 0 and active 0.
- R2: When `pixAdv` is high on an edge and the line is not at its end, the pixel count rises by one. When `pixAdv` is low, all four outputs hold their values.
- R3: `stdSel` encoding is 0 = 525-line 601 (858 total pixels, 720 active), 1 = 525-line square (780/640), 2 = 625-line 601 (864/720), 3 = 625-line square (944/768). A strobe taken at pixel count total-1 sets the pixel count to 0 and advances the line.
- R4: Lines are numbered from 1. A line advance taken at the frame's last line (525 or 625) returns the line count to 1. The line count is never 0.
- R5: The field output is 0 from line 1 up to and including line 262 (525-line) or line 310 (625-line). It is 1 from line 263 (525-line) or line 311 (625-line) to the end of the frame.
- R6: The horizontal window covers pixel counts from hStart up to but not including total - FrontPorch, where hStart = total - activeWidth - FrontPorch and FrontPorch defaults to 16. This gives hStart values of 122, 124, 128 and 160 for encodings 0 to 3.
- R7: The vertical window covers lines 23..262 and 285..524 for 525-line standards, and lines 23..310 and 336..623 for 625-line standards. All other lines are inactive.
- R8: ACTIVE is the AND of the two windows. It is evaluated on the new pixel and line positions with the standard in effect at the advancing strobe, and it changes on the same edge as the counts it describes.
- R9: If a standard change leaves the pixel count at or beyond the new total-1, the next strobe sets the pixel count to 0 and advances the line. A line count at or beyond the new frame total likewise returns to 1 at the next line advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixAdv | input | 1 | Advances the position by one pixel |
| stdSel | input | 2 | Video standard and sampling select |
| pixCount | output | 10 | Pixel position within the line, from 0 |
| lineCount | output | 10 | Line number within the frame, from 1 |
| field | output | 1 | 0 in the first field, 1 in the second |
| active | output | 1 | Pixel is inside the visible picture |

## Verification
Each standard is first run with the strobe high on every cycle for a full frame and beyond. This covers every line-window edge, the field change and the frame wrap, and it tells apart the per-standard line tables. A second instance with reduced pixel totals makes these full frames short, while the default instance confirms the broadcast pixel windows. A randomly gapped strobe then separates true holding from free-running counting. Random standard switches during a line, plus one directed switch to a shorter line, exercise the catch-up wrap of R9.

// File: rtl/vidRegionPkg.sv
package vidRegionPkg;
  localparam int CntW = 10;
  typedef logic [CntW-1:0] cnt_t;

  typedef enum logic [1:0] {
    STD525RECT = 2'd0,
    STD525SQ   = 2'd1,
    STD625RECT = 2'd2,
    STD625SQ   = 2'd3
  } vidStd_e;

  localparam int NumStd = 4;

  // Line windows, first index 525-line, second 625-line
  localparam int LinesA   = 525;
  localparam int LinesB   = 625;
  localparam int VisFirst = 23;
  localparam int F1LastA  = 262;
  localparam int F1LastB  = 310;
  localparam int F2StartA = 285;
  localparam int F2StartB = 336;
  localparam int F2LastA  = 524;
  localparam int F2LastB  = 623;

  typedef struct packed {
    cnt_t pixTotal;
    cnt_t hStart;
    cnt_t hEnd;
    cnt_t lineTotal;
    cnt_t f1First;
    cnt_t f1Last;
    cnt_t f2Mark;
    cnt_t f2First;
    cnt_t f2Last;
  } winCfg_t;

  typedef struct packed {
    logic lineStep;
    logic frameWrap;
    logic enterField2;
  } stepStrobes_t;
endpackage

// File: rtl/vidRegionCtrl.sv
module vidRegionCtrl
  import vidRegionPkg::*;
#(
  parameter int PixTotRect525 = 858,
  parameter int PixTotRect625 = 864,
  parameter int PixActRect    = 720,
  parameter int PixTotSq525   = 780,
  parameter int PixActSq525   = 640,
  parameter int PixTotSq625   = 944,
  parameter int PixActSq625   = 768,
  parameter int FrontPorch    = 16
) (
  input  logic         pixAdv,
  input  logic [1:0]   stdSel,
  input  cnt_t         pixCount,
  input  cnt_t         lineCount,
  output winCfg_t      cfg,
  output stepStrobes_t strobes
);
  localparam int PixTot [NumStd] = '{PixTotRect525, PixTotSq525, PixTotRect625, PixTotSq625};
  localparam int PixAct [NumStd] = '{PixActRect, PixActSq525, PixActRect, PixActSq625};

  winCfg_t stdTable [NumStd];

  for (genvar g = 0; g < NumStd; g++) begin : g_std
    localparam bit Is625 = (g >= 2);
    localparam int HStart = PixTot[g] - PixAct[g] - FrontPorch;
    assign stdTable[g] = '{
      pixTotal:  cnt_t'(PixTot[g]),
      hStart:    cnt_t'(HStart),
      hEnd:      cnt_t'(HStart + PixAct[g]),
      lineTotal: cnt_t'(Is625 ? LinesB : LinesA),
      f1First:   cnt_t'(VisFirst),
      f1Last:    cnt_t'(Is625 ? F1LastB : F1LastA),
      f2Mark:    cnt_t'(Is625 ? F1LastB + 1 : F1LastA + 1),
      f2First:   cnt_t'(Is625 ? F2StartB : F2StartA),
      f2Last:    cnt_t'(Is625 ? F2LastB : F2LastA)
    };
  end

  assign cfg = stdTable[stdSel];

  always_comb begin
    strobes.lineStep    = pixAdv && (pixCount >= cfg.pixTotal - cnt_t'(1));
    strobes.frameWrap   = strobes.lineStep && (lineCount >= cfg.lineTotal);
    strobes.enterField2 = strobes.lineStep && !strobes.frameWrap &&
                          ((lineCount + cnt_t'(1)) == cfg.f2Mark);
  end
endmodule

// File: rtl/vidRegionPath.sv
module vidRegionPath
  import vidRegionPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         pixAdv,
  input  winCfg_t      cfg,
  input  stepStrobes_t strobes,
  output cnt_t         pixCount,
  output cnt_t         lineCount,
  output logic         field,
  output logic         active
);
  cnt_t nextPix;
  cnt_t nextLine;
  logic hWin;
  logic vWin;

  always_comb begin
    nextPix  = strobes.lineStep ? '0 : pixCount + cnt_t'(1);
    nextLine = lineCount;
    if (strobes.lineStep) nextLine = strobes.frameWrap ? cnt_t'(1) : lineCount + cnt_t'(1);
    hWin = (nextPix >= cfg.hStart) && (nextPix < cfg.hEnd);
    vWin = ((nextLine >= cfg.f1First) && (nextLine <= cfg.f1Last)) ||
           ((nextLine >= cfg.f2First) && (nextLine <= cfg.f2Last));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixCount  <= '0;
      lineCount <= cnt_t'(1);
      field     <= 1'b0;
      active    <= 1'b0;
    end else if (pixAdv) begin
      pixCount  <= nextPix;
      lineCount <= nextLine;
      if (strobes.frameWrap)        field <= 1'b0;
      else if (strobes.enterField2) field <= 1'b1;
      active    <= hWin && vWin;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !pixAdv |=> ($stable(pixCount) && $stable(lineCount) && $stable(field) && $stable(active)));

  assert_pix_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (pixAdv && (pixCount >= cfg.pixTotal - cnt_t'(1))) |=>
      (pixCount == '0 && lineCount != $past(lineCount)));

  assert_line_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.lineStep && lineCount >= cfg.lineTotal) |=> (lineCount == cnt_t'(1) && !field));

  assert_line_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    lineCount != '0);

  assert_active_lines_R7: assert property (@(posedge clk) disable iff (rst)
    active |-> (lineCount >= cnt_t'(VisFirst) && lineCount <= cnt_t'(F2LastB)));
endmodule

// File: rtl/vidRegionGen.sv
module vidRegionGen
  import vidRegionPkg::*;
#(
  parameter int PixTotRect525 = 858,
  parameter int PixTotRect625 = 864,
  parameter int PixActRect    = 720,
  parameter int PixTotSq525   = 780,
  parameter int PixActSq525   = 640,
  parameter int PixTotSq625   = 944,
  parameter int PixActSq625   = 768,
  parameter int FrontPorch    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pixAdv,
  input  logic [1:0]      stdSel,
  output logic [CntW-1:0] pixCount,
  output logic [CntW-1:0] lineCount,
  output logic            field,
  output logic            active
);
  winCfg_t      cfg;
  stepStrobes_t strobes;

  vidRegionCtrl #(
    .PixTotRect525(PixTotRect525), .PixTotRect625(PixTotRect625), .PixActRect(PixActRect),
    .PixTotSq525(PixTotSq525), .PixActSq525(PixActSq525),
    .PixTotSq625(PixTotSq625), .PixActSq625(PixActSq625), .FrontPorch(FrontPorch)
  ) u_ctrl (
    .pixAdv(pixAdv), .stdSel(stdSel), .pixCount(pixCount), .lineCount(lineCount),
    .cfg(cfg), .strobes(strobes)
  );

  vidRegionPath u_path (
    .clk(clk), .rst(rst), .pixAdv(pixAdv), .cfg(cfg), .strobes(strobes),
    .pixCount(pixCount), .lineCount(lineCount), .field(field), .active(active)
  );
endmodule

// File: tb/vidRegionGen_bench.sv
module vidRegionGen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixAdv = 1'b0;
  logic [1:0] stdSel = 2'd0;
  logic [9:0] bPixO, bLineO, sPixO, sLineO;
  logic bFieldO, bActO, sFieldO, sActO;

  int nChk = 0;
  int nFail = 0;
  int bPix, bLine, bFld, bAct;
  int sPix, sLine, sFld, sAct;

  always #2 clk = ~clk;

  vidRegionGen u_vidRegionGen (
    .clk(clk), .rst(rst), .pixAdv(pixAdv), .stdSel(stdSel),
    .pixCount(bPixO), .lineCount(bLineO), .field(bFieldO), .active(bActO));

  vidRegionGen #(
    .PixTotRect525(30), .PixTotRect625(32), .PixActRect(10),
    .PixTotSq525(26), .PixActSq525(8), .PixTotSq625(36), .PixActSq625(14),
    .FrontPorch(16)
  ) u_vidRegionGenSmall (
    .clk(clk), .rst(rst), .pixAdv(pixAdv), .stdSel(stdSel),
    .pixCount(sPixO), .lineCount(sLineO), .field(sFieldO), .active(sActO));

  function automatic int expTot(bit sm, int s);
    if (sm) return (s == 0) ? 30 : (s == 1) ? 26 : (s == 2) ? 32 : 36;
    return (s == 0) ? 858 : (s == 1) ? 780 : (s == 2) ? 864 : 944;
  endfunction

  function automatic int expWid(bit sm, int s);
    if (sm) return (s == 1) ? 8 : (s == 3) ? 14 : 10;
    return (s == 1) ? 640 : (s == 3) ? 768 : 720;
  endfunction

  function automatic bit expV(int s, int ln);
    if (s >= 2) return (ln >= 23 && ln <= 310) || (ln >= 336 && ln <= 623);
    return (ln >= 23 && ln <= 262) || (ln >= 285 && ln <= 524);
  endfunction

  function automatic bit expH(bit sm, int s, int px);
    int hs;
    int he;
    he = expTot(sm, s) - 16;
    hs = he - expWid(sm, s);
    return px >= hs && px < he;
  endfunction

  task automatic mstep(input bit sm, input int s, inout int px, inout int ln,
                       inout int fl, inout int ac);
    int tot;
    int lt;
    int mark;
    tot = expTot(sm, s);
    lt = (s >= 2) ? 625 : 525;
    mark = (s >= 2) ? 311 : 263;
    if (px >= tot - 1) begin
      px = 0;
      if (ln >= lt) begin ln = 1; fl = 0; end
      else begin ln++; if (ln == mark) fl = 1; end
    end else px++;
    ac = (expH(sm, s, px) && expV(s, ln)) ? 1 : 0;
  endtask

  function automatic string actTag(bit sm, int s, int px, int ln);
    int he;
    int hs;
    he = expTot(sm, s) - 16;
    hs = he - expWid(sm, s);
    if (px == hs || px == hs - 1 || px == he || px == he - 1) return "R6";
    if (ln == 22 || ln == 23 || ln == 262 || ln == 263 || ln == 284 || ln == 285 ||
        ln == 310 || ln == 311 || ln == 335 || ln == 336 || ln == 524 || ln == 623 ||
        ln == 624) return "R7";
    return "R8";
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    cmp((bPix == 0) ? "R3" : "R2", "pixCount", int'(bPixO), bPix);
    cmp("R4", "lineCount", int'(bLineO), bLine);
    cmp("R5", "field", int'(bFieldO), bFld);
    cmp(actTag(1'b0, int'(stdSel), bPix, bLine), "active", int'(bActO), bAct);
    cmp((sPix == 0) ? "R3" : "R2", "small pixCount", int'(sPixO), sPix);
    cmp("R4", "small lineCount", int'(sLineO), sLine);
    cmp("R5", "small field", int'(sFieldO), sFld);
    cmp(actTag(1'b1, int'(stdSel), sPix, sLine), "small active", int'(sActO), sAct);
  endtask

  // inputs are set at a falling edge before calling
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      bPix = 0; bLine = 1; bFld = 0; bAct = 0;
      sPix = 0; sLine = 1; sFld = 0; sAct = 0;
    end else if (pixAdv) begin
      mstep(1'b0, int'(stdSel), bPix, bLine, bFld, bAct);
      mstep(1'b1, int'(stdSel), sPix, sLine, sFld, sAct);
    end
    @(negedge clk);
    if (!rst) checkAll();
  endtask

  task automatic doReset();
    rst = 1'b1;
    pixAdv = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1..all run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    doReset();
    // R1: reset state seen at the ports
    cmp("R1", "reset pixCount", int'(bPixO), 0);
    cmp("R1", "reset lineCount", int'(bLineO), 1);
    cmp("R1", "reset field", int'(bFieldO), 0);
    cmp("R1", "reset active", int'(bActO), 0);

    // full frames per standard with a continuous strobe (R3..R8)
    for (int s = 0; s < 4; s++) begin
      stdSel = 2'(s);
      doReset();
      pixAdv = 1'b1;
      for (int c = 0; c < ((s >= 2) ? 645 : 545) * expTot(1'b1, s); c++) tick();
    end

    // R9: switch to a shorter line while past its end
    stdSel = 2'd3;
    doReset();
    pixAdv = 1'b1;
    repeat (900) tick();
    cmp("R9", "pixCount before switch", int'(bPixO), 900);
    stdSel = 2'd1;
    tick();
    cmp("R9", "pixCount after switch", int'(bPixO), 0);
    cmp("R9", "lineCount after switch", int'(bLineO), 2);

    // R2 hold with strobe low
    pixAdv = 1'b0;
    repeat (5) tick();
    cmp("R2", "held pixCount", int'(bPixO), 0);

    // random gaps and standard switches (R2, R9)
    for (int i = 0; i < 60000; i++) begin
      if (i % 3000 == 0) stdSel = 2'($urandom % 4);
      pixAdv = ($urandom % 4) != 0;
      tick();
    end

    summary();
    $finish;
  end
endmodule